// File: doc/BRIEF.md
# Lowest-Priority Interrupt Router

This block takes interrupt messages and steers each one to one or more of `N_TGT` processor targets (four by default). A message carries a vector, a destination mask and a delivery mode. In fixed mode the vector goes to every target named in the mask. In broadcast mode it goes to every target, whatever the mask says. In lowest-priority mode it goes to exactly one target: the masked target whose task priority value is smallest. When several masked targets share that smallest value, a rotating pointer decides between them.

Each target has a 4-bit task priority register, written through a small register port and read at arbitration. Messages arrive on two ports. The general input port takes any vector. The inter-processor port takes only vectors 251 to 255 and wins when both ports offer a message in the same cycle. The router holds a single message. It accepts no new one until every target it addressed has taken the vector through its own valid/ready handshake.

A control machine with three states sequences the work. IDLE accepts a message (IDLE to ARB on a capture). ARB computes the target set and either drops the message (ARB to IDLE on a bad message) or starts delivery (ARB to SEND). SEND presents the vector on the addressed lanes and returns to IDLE once the last pending lane has been accepted (SEND to IDLE on drain).

Top module: `lpr_router`

## Requirements
- R1: Mode 2'b00 (fixed) delivers the vector to exactly the targets whose bit is set in the destination mask.
- R2: Mode 2'b01 (broadcast) delivers the vector to every target and ignores the destination mask.
- R3: Mode 2'b10 (lowest priority) delivers to one target only, chosen among masked targets as the one with the smallest task priority value.
- R4: When several masked targets share the smallest value, the winner is the first tied target found by searching upward (with wrap) from a rotating pointer. The pointer then moves to the target just past the winner. It does not move when no tie was broken. The pointer is 0 after reset.
- R5: Task priority registers reset to 0. A write (index, 4-bit value) made while the router is idle is used by the next arbitration.
- R6: After a message is accepted, both input ready outputs stay low until all addressed targets have accepted. A lane whose ready is low keeps its valid and vector unchanged.
- R7: A fixed or lowest-priority message with an empty mask is dropped. No lane becomes valid, and `err_drop` pulses high for one cycle.
- R8: The inter-processor port accepts only vectors 251 to 255 and drops any other vector with an `err_drop` pulse. When both ports are valid in an idle cycle, the inter-processor port is taken and `in_ready` is low.
- R9: After reset no lane is valid, `err_drop` is low and both ready outputs are high.
- R10: Mode 2'b11 is reserved. Such a message is dropped with an `err_drop` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | General message offered |
| in_ready | output | 1 | General message taken on this edge when valid |
| in_vector | input | VEC_W | Vector of general message |
| in_dest | input | N_TGT | Destination mask of general message |
| in_mode | input | 2 | Delivery mode of general message |
| ipi_valid | input | 1 | Inter-processor message offered |
| ipi_ready | output | 1 | Inter-processor message taken on this edge when valid |
| ipi_vector | input | VEC_W | Vector of inter-processor message |
| ipi_dest | input | N_TGT | Destination mask of inter-processor message |
| ipi_mode | input | 2 | Delivery mode of inter-processor message |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_idx | input | IDX_W | Target whose task priority is written |
| tpr_wdata | input | PRIO_W | Task priority value to write |
| out_valid | output | N_TGT | Per-target vector valid |
| out_ready | input | N_TGT | Per-target acceptance |
| out_vector | output | N_TGT*VEC_W | Per-target vector, lane i at bits i*VEC_W |
| err_drop | output | 1 | One-cycle pulse when a message is dropped |

## Verification
A message offered while idle is captured on the first clock edge. Arbitration happens on the second edge, and from that edge on the lane valids or the `err_drop` pulse can be seen. With all lanes ready, the third edge drains the message and the ready outputs rise again. The bench drives its inputs on falling edges and samples on the falling edge after the edge that makes each result. It reads lane valids and vectors one edge after capture plus one. It reads ready recovery one edge later. In the backpressure case it reads lane state after each further edge. Task priority writes are finished before the message is offered, so the arbitration edge always sees the written values.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

    typedef enum logic [1:0] {
        MODE_FIXED  = 2'b00,
        MODE_BCAST  = 2'b01,
        MODE_LOWEST = 2'b10,
        MODE_RSVD   = 2'b11
    } dmode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ARB  = 2'b01,
        ST_SEND = 2'b10
    } rstate_e;

endpackage

// File: rtl/lpr_tpr_bank.sv
module lpr_tpr_bank #(
    parameter int N_TGT  = 4,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(N_TGT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [PRIO_W-1:0]       wr_data,
    output logic [N_TGT*PRIO_W-1:0] prio_flat
);

    for (genvar i = 0; i < N_TGT; i++) begin : g_tpr
        logic [PRIO_W-1:0] tpr_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tpr_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                tpr_q <= wr_data;
            end
        end
        assign prio_flat[i*PRIO_W +: PRIO_W] = tpr_q;
    end

endmodule

// File: rtl/lpr_lowest_pick.sv
module lpr_lowest_pick #(
    parameter int N_TGT  = 4,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(N_TGT)
) (
    input  logic [N_TGT-1:0]        cand,
    input  logic [N_TGT*PRIO_W-1:0] prio_flat,
    input  logic [IDX_W-1:0]        rr_ptr,
    output logic [N_TGT-1:0]        pick,
    output logic [IDX_W-1:0]        pick_idx,
    output logic                    tie
);

    logic [PRIO_W-1:0] min_v;
    logic [N_TGT-1:0]  tie_set;
    logic              found;
    int                tie_cnt;
    int                j;

    // smallest priority value among the candidates
    always_comb begin
        min_v = '1;
        for (int i = 0; i < N_TGT; i++) begin
            if (cand[i] && (prio_flat[i*PRIO_W +: PRIO_W] < min_v)) begin
                min_v = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // candidates sharing that value
    always_comb begin
        tie_cnt = 0;
        for (int i = 0; i < N_TGT; i++) begin
            tie_set[i] = cand[i] && (prio_flat[i*PRIO_W +: PRIO_W] == min_v);
            if (tie_set[i]) tie_cnt = tie_cnt + 1;
        end
        tie = (tie_cnt > 1);
    end

    // first tied candidate at or after the rotating pointer
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        j        = 0;
        for (int k = 0; k < N_TGT; k++) begin
            j = int'(rr_ptr) + k;
            if (j >= N_TGT) j = j - N_TGT;
            if (!found && tie_set[j]) begin
                found    = 1'b1;
                pick_idx = IDX_W'(j);
            end
        end
        pick = found ? (N_TGT'(1) << pick_idx) : '0;
    end

endmodule

// File: rtl/lpr_router.sv
module lpr_router
    import lpr_pkg::*;
#(
    parameter int N_TGT      = 4,
    parameter int VEC_W      = 8,
    parameter int PRIO_W     = 4,
    parameter int IPI_VEC_LO = 251,
    localparam int IDX_W     = $clog2(N_TGT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [VEC_W-1:0]       in_vector,
    input  logic [N_TGT-1:0]       in_dest,
    input  logic [1:0]             in_mode,
    input  logic                   ipi_valid,
    output logic                   ipi_ready,
    input  logic [VEC_W-1:0]       ipi_vector,
    input  logic [N_TGT-1:0]       ipi_dest,
    input  logic [1:0]             ipi_mode,
    input  logic                   tpr_we,
    input  logic [IDX_W-1:0]       tpr_idx,
    input  logic [PRIO_W-1:0]      tpr_wdata,
    output logic [N_TGT-1:0]       out_valid,
    input  logic [N_TGT-1:0]       out_ready,
    output logic [N_TGT*VEC_W-1:0] out_vector,
    output logic                   err_drop
);

    rstate_e state_q, state_d;

    logic [VEC_W-1:0]        vec_q;
    logic [N_TGT-1:0]        dest_q;
    dmode_e                  mode_q;
    logic                    src_ipi_q;
    logic [N_TGT-1:0]        pend_q;
    logic [IDX_W-1:0]        rr_q;
    logic                    err_q;

    logic [N_TGT*PRIO_W-1:0] prio_flat;
    logic [N_TGT-1:0]        pick;
    logic [IDX_W-1:0]        pick_idx;
    logic                    tie;

    logic                    take_ipi, take_in;
    logic                    bad_msg;
    logic [N_TGT-1:0]        tgt_set;
    logic [N_TGT-1:0]        pend_left;

    lpr_tpr_bank #(.N_TGT(N_TGT), .PRIO_W(PRIO_W)) u_tpr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tpr_we),
        .wr_idx   (tpr_idx),
        .wr_data  (tpr_wdata),
        .prio_flat(prio_flat)
    );

    lpr_lowest_pick #(.N_TGT(N_TGT), .PRIO_W(PRIO_W)) u_pick (
        .cand     (dest_q),
        .prio_flat(prio_flat),
        .rr_ptr   (rr_q),
        .pick     (pick),
        .pick_idx (pick_idx),
        .tie      (tie)
    );

    assign take_ipi  = (state_q == ST_IDLE) && ipi_valid;
    assign take_in   = (state_q == ST_IDLE) && in_valid && !ipi_valid;
    assign pend_left = pend_q & ~out_ready;

    // message screening and target set, evaluated in ARB
    always_comb begin
        bad_msg = (mode_q == MODE_RSVD)
               || ((mode_q != MODE_BCAST) && (dest_q == '0))
               || (src_ipi_q && (vec_q < VEC_W'(IPI_VEC_LO)));
        unique case (mode_q)
            MODE_BCAST:  tgt_set = '1;
            MODE_LOWEST: tgt_set = pick;
            default:     tgt_set = dest_q;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take_ipi || take_in) state_d = ST_ARB;
            ST_ARB:  state_d = bad_msg ? ST_IDLE : ST_SEND;
            ST_SEND: if (pend_left == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // message holding, pending lanes, tie pointer, drop pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q     <= '0;
            dest_q    <= '0;
            mode_q    <= MODE_FIXED;
            src_ipi_q <= 1'b0;
            pend_q    <= '0;
            rr_q      <= '0;
            err_q     <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (take_ipi) begin
                        vec_q     <= ipi_vector;
                        dest_q    <= ipi_dest;
                        mode_q    <= dmode_e'(ipi_mode);
                        src_ipi_q <= 1'b1;
                    end else if (take_in) begin
                        vec_q     <= in_vector;
                        dest_q    <= in_dest;
                        mode_q    <= dmode_e'(in_mode);
                        src_ipi_q <= 1'b0;
                    end
                end
                ST_ARB: begin
                    pend_q <= bad_msg ? '0 : tgt_set;
                    err_q  <= bad_msg;
                    if (!bad_msg && (mode_q == MODE_LOWEST) && tie) begin
                        rr_q <= (pick_idx == IDX_W'(N_TGT-1)) ? '0 : pick_idx + 1'b1;
                    end
                end
                ST_SEND: pend_q <= pend_left;
                default: pend_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE) && !ipi_valid;
        ipi_ready = (state_q == ST_IDLE);
        out_valid = (state_q == ST_SEND) ? pend_q : '0;
        err_drop  = err_q;
    end

    for (genvar i = 0; i < N_TGT; i++) begin : g_lane
        assign out_vector[i*VEC_W +: VEC_W] = vec_q;

        p_hold_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[i] && !out_ready[i]) |=>
            (out_valid[i] && $stable(out_vector[i*VEC_W +: VEC_W])));

        p_pick_is_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_ARB && mode_q == MODE_LOWEST && dest_q[i]) |->
            (prio_flat[i*PRIO_W +: PRIO_W] >= prio_flat[pick_idx*PRIO_W +: PRIO_W]));
    end

    p_accept_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_single_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND && mode_q == MODE_LOWEST) |-> $onehot0(out_valid));

    p_pick_in_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARB && dest_q != '0) |->
        (($countones(pick) == 1) && ((pick & ~dest_q) == '0)));

    p_bcast_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARB && mode_q == MODE_BCAST &&
         !(src_ipi_q && vec_q < VEC_W'(IPI_VEC_LO))) |=> (out_valid == '1));

    p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_drop |=> !err_drop);

    p_err_no_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_drop |-> (out_valid == '0));

    p_rr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARB && !(mode_q == MODE_LOWEST && tie && !bad_msg)) |=> $stable(rr_q));

    p_ipi_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_valid |-> !in_ready);

endmodule

// File: tb/lpr_router_bench.sv
module lpr_router_bench;

    localparam int N_TGT = 4;
    localparam int VEC_W = 8;
    localparam int NVEC  = 15;
    // {tpr3,tpr2,tpr1,tpr0, vector, dest, mode, expected lanes, expected err, req id}
    localparam logic [38:0] VEC_TABLE [NVEC] = '{
        {16'h0000, 8'h40, 4'b0101, 2'b00, 4'b0101, 1'b0, 4'd1},
        {16'h0000, 8'h41, 4'b0001, 2'b01, 4'b1111, 1'b0, 4'd2},
        {16'h5279, 8'h42, 4'b1111, 2'b10, 4'b0100, 1'b0, 4'd3},
        {16'h5279, 8'h43, 4'b1011, 2'b10, 4'b1000, 1'b0, 4'd3},
        {16'h3333, 8'h44, 4'b1111, 2'b10, 4'b0001, 1'b0, 4'd4},
        {16'h3333, 8'h45, 4'b1111, 2'b10, 4'b0010, 1'b0, 4'd4},
        {16'h1444, 8'h46, 4'b0111, 2'b10, 4'b0100, 1'b0, 4'd4},
        {16'h3333, 8'h47, 4'b0011, 2'b10, 4'b0001, 1'b0, 4'd4},
        {16'h0660, 8'h48, 4'b1001, 2'b10, 4'b1000, 1'b0, 4'd4},
        {16'h3333, 8'h49, 4'b0010, 2'b10, 4'b0010, 1'b0, 4'd4},
        {16'h3333, 8'h4A, 4'b1111, 2'b10, 4'b0001, 1'b0, 4'd4},
        {16'h3333, 8'h4B, 4'b0000, 2'b00, 4'b0000, 1'b1, 4'd7},
        {16'h3333, 8'h4C, 4'b0000, 2'b10, 4'b0000, 1'b1, 4'd7},
        {16'h3333, 8'h4D, 4'b1111, 2'b11, 4'b0000, 1'b1, 4'd10},
        {16'h3339, 8'h4E, 4'b1111, 2'b10, 4'b0010, 1'b0, 4'd5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, ipi_valid = 1'b0, tpr_we = 1'b0;
    logic in_ready, ipi_ready, err_drop;
    logic [VEC_W-1:0] in_vector = '0, ipi_vector = '0;
    logic [N_TGT-1:0] in_dest = '0, ipi_dest = '0;
    logic [1:0] in_mode = '0, ipi_mode = '0;
    logic [1:0] tpr_idx = '0;
    logic [3:0] tpr_wdata = '0;
    logic [N_TGT-1:0] out_valid;
    logic [N_TGT-1:0] out_ready = '1;
    logic [N_TGT*VEC_W-1:0] out_vector;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lpr_router u_lpr_router (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_vector(in_vector),
        .in_dest(in_dest), .in_mode(in_mode),
        .ipi_valid(ipi_valid), .ipi_ready(ipi_ready), .ipi_vector(ipi_vector),
        .ipi_dest(ipi_dest), .ipi_mode(ipi_mode),
        .tpr_we(tpr_we), .tpr_idx(tpr_idx), .tpr_wdata(tpr_wdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_vector(out_vector),
        .err_drop(err_drop)
    );

    function automatic string req_name(input logic [3:0] id);
        case (id)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd7:    return "R7";
            4'd10:   return "R10";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // every valid lane must carry the expected vector
    function automatic bit lanes_ok(input logic [N_TGT-1:0] lanes, input logic [VEC_W-1:0] v);
        for (int i = 0; i < N_TGT; i++)
            if (lanes[i] && out_vector[i*VEC_W +: VEC_W] != v) return 1'b0;
        return 1'b1;
    endfunction

    task automatic write_tprs(input logic [15:0] vals);
        for (int i = 0; i < N_TGT; i++) begin
            @(negedge clk);
            tpr_we = 1'b1; tpr_idx = 2'(i); tpr_wdata = vals[i*4 +: 4];
        end
        @(negedge clk);
        tpr_we = 1'b0;
    endtask

    // offer one message on the chosen port; check lanes and drop pulse after arbitration
    task automatic run_msg(input bit ipi, input logic [7:0] v, input logic [3:0] d,
                           input logic [1:0] m, input logic [3:0] exp_lanes,
                           input bit exp_err, input string tag);
        @(negedge clk);
        if (ipi) begin ipi_valid = 1'b1; ipi_vector = v; ipi_dest = d; ipi_mode = m; end
        else     begin in_valid  = 1'b1; in_vector  = v; in_dest  = d; in_mode  = m; end
        @(posedge clk);                 // capture edge
        @(negedge clk);
        ipi_valid = 1'b0; in_valid = 1'b0;
        @(posedge clk);                 // arbitration edge
        @(negedge clk);
        check(out_valid == exp_lanes, tag, "lanes", 32'(out_valid), 32'(exp_lanes));
        check(err_drop == exp_err, tag, "err_drop", 32'(err_drop), 32'(exp_err));
        check(lanes_ok(out_valid, v), tag, "lane vector", 32'(out_vector), 32'(v));
        @(posedge clk);                 // drain edge
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == '0, tag, "idle again",
              {30'd0, in_ready, |out_valid}, 32'h2);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(out_valid == '0, "R9", "lanes after reset", 32'(out_valid), 32'h0);
        check(err_drop == 1'b0, "R9", "err after reset", 32'(err_drop), 32'h0);
        check(in_ready && ipi_ready, "R9", "ready after reset",
              {30'd0, in_ready, ipi_ready}, 32'h3);

        // table walk: R1 R2 R3 R4 R5 R7 R10
        for (int e = 0; e < NVEC; e++) begin
            write_tprs(VEC_TABLE[e][38:23]);
            run_msg(1'b0, VEC_TABLE[e][22:15], VEC_TABLE[e][14:11], VEC_TABLE[e][10:9],
                    VEC_TABLE[e][8:5], VEC_TABLE[e][4], req_name(VEC_TABLE[e][3:0]));
        end

        // R6: backpressure on lane 1 while lane 2 accepts
        @(negedge clk);
        out_ready = 4'b0100;
        in_valid = 1'b1; in_vector = 8'h60; in_dest = 4'b0110; in_mode = 2'b00;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R6", "ready after accept", 32'(in_ready), 32'h0);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 4'b0110, "R6", "lanes presented", 32'(out_valid), 32'h6);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 4'b0010, "R6", "lane 2 taken", 32'(out_valid), 32'h2);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(out_valid == 4'b0010 && out_vector[15:8] == 8'h60, "R6", "lane 1 held",
              {16'd0, out_vector[15:8], 4'd0, out_valid}, 32'h6002);
        check(in_ready == 1'b0 && ipi_ready == 1'b0, "R6", "ready held low",
              {30'd0, in_ready, ipi_ready}, 32'h0);
        out_ready = 4'b1111;
        @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == '0, "R6", "released",
              {30'd0, in_ready, |out_valid}, 32'h2);

        // R8: inter-processor port
        run_msg(1'b1, 8'd251, 4'b1000, 2'b00, 4'b1000, 1'b0, "R8");
        run_msg(1'b1, 8'd250, 4'b1000, 2'b00, 4'b0000, 1'b1, "R8");

        // R8: both ports at once, inter-processor message goes first
        @(negedge clk);
        ipi_valid = 1'b1; ipi_vector = 8'd255; ipi_dest = 4'b0001; ipi_mode = 2'b01;
        in_valid  = 1'b1; in_vector  = 8'h50;  in_dest  = 4'b0001; in_mode  = 2'b00;
        #1;
        check(in_ready == 1'b0 && ipi_ready == 1'b1, "R8", "port precedence",
              {30'd0, in_ready, ipi_ready}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        ipi_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 4'b1111 && lanes_ok(out_valid, 8'd255), "R8", "ipi broadcast",
              32'(out_valid), 32'hF);
        @(posedge clk);                 // drain
        @(posedge clk);                 // general message captured
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 4'b0001 && lanes_ok(out_valid, 8'h50), "R8", "deferred message",
              32'(out_valid), 32'h1);
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule